// File: doc/BRIEF.md
# Zero-Skipping 8x8 Inverse Transform Sequencer

This block runs a complete two-dimensional 8x8 inverse DCT on one block of quantised coefficients. It drives an external one-dimensional transform datapath twice. The first pass transforms columns. It handles the block as two halves of four columns each, left then right. The second pass transforms rows. The sequencer fetches coefficients and quantisation factors one row of four values per cycle, multiplies them to dequantise, and stores the first-pass results transposed in two small workspaces. It then emits the 64 reconstructed samples one at a time in raster order.

While a half is being fetched, the sequencer tests it for zero rows. It then chooses one of three paths for that half: a full column transform, a reduced transform that assumes rows 4-7 are zero, or a DC shortcut that skips the datapath. A right half that is entirely zero writes nothing to the workspaces. In that case the second pass runs in its reduced form for every row.

Top module: `idct_zskip_seq`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are all low.
- R2: For each half (0 = left, 1 = right), rows 0 to 7 are read in that order. The coefficient and quantisation ports carry the same address `{row[2:0], half}`, and data returns on the cycle after the read enable. Lane i of a read word is column 4*half+i.
- R3: A dequantised value is the low `WW` bits of the signed product of the coefficient and the quantisation factor.
- R4: A half whose raw coefficients in rows 4-7 are not all zero is column-transformed with `dp_mode` 0. Lane j of `dp_in` carries dequantised row j.
- R5: A half whose rows 4-7 are all zero, but which has some nonzero coefficient in rows 1-3, is transformed with `dp_mode` 1.
- R6: A half whose rows 1-7 are all zero issues no datapath request. Every workspace entry of each of its columns receives that column's dequantised row-0 value shifted left by two. A left half that is entirely zero takes this path.
- R7: A right half that is entirely zero writes no workspace entry. Every second-pass request then uses `dp_mode` 3 with lanes 4-7 of `dp_in` forced to zero, so leftover workspace contents from earlier blocks have no effect.
- R8: In all other cases every second-pass request uses `dp_mode` 2 with all eight lanes taken from the workspace.
- R9: Transpose: for column c, first-pass outputs 0-3 go to the left workspace and outputs 4-7 go to the right workspace, each at row c. Output row k (k<4 from the left workspace, otherwise from the right) is transformed from entry k mod 4 of workspace rows 0-7 in lane order.
- R10: Output sample `out_idx` = 8*k+j carries lane j of the second-pass result for row k. It becomes visible 28+9k+j cycles after the clock edge that accepts `start`.
- R11: `done` is high for exactly one cycle, on the cycle after the sample with index 63. That is 99 cycles after the accepting edge.
- R12: `start` has no effect while `busy` is high. No extra samples are produced and the latencies stay unchanged.
- R13: Classification of a half finishes before its first datapath request. No datapath request is made while a fetch is under way.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one block (sampled while idle) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| coef_rd_en | output | 1 | Coefficient memory read enable |
| coef_addr | output | 4 | Coefficient row address {row, half} |
| coef_rdata | input | 4*CW | Four coefficients, one cycle after read |
| q_rd_en | output | 1 | Quantisation memory read enable |
| q_addr | output | 4 | Quantisation row address {row, half} |
| q_rdata | input | 4*QW | Four quantisation factors |
| dp_req | output | 1 | Datapath request strobe |
| dp_mode | output | 2 | 0 col full, 1 col reduced, 2 row full, 3 row reduced |
| dp_in | output | 8*WW | Eight input lanes to the datapath |
| dp_out | input | 8*WW | Eight result lanes, combinational from dp_in |
| out_valid | output | 1 | Sample valid |
| out_idx | output | 6 | Raster index 8*row+column |
| out_data | output | WW | Sample value |

## Verification
Every result of this block has a fixed due time relative to the edge that accepts `start`. The fetch and column phases always take 26 cycles, whatever path each half takes. Sample (k, j) then appears 28+9k+j cycles after that edge, and `done` appears at 99. The bench records the cycle count when it drives `start` and pushes each expected sample into a queue. At each falling edge, the monitor compares the data, the index and the exact cycle of every sample it pops. Because of this, a path that takes a shortcut in time or emits a stray sample shows up as a miscompare, not only a path that gets the arithmetic wrong. The datapath is modelled as a position-weighted sum plus a mode offset. A wrong mode, a wrong lane or a stale workspace read changes the values that the bench compares.

// File: rtl/idct_seq_pkg.sv
package idct_seq_pkg;
    localparam int BLK     = 8;                 // transform size
    localparam int HALF_W  = BLK / 2;           // columns per half
    localparam int ROW_AW  = $clog2(BLK);
    localparam int ADDR_W  = ROW_AW + 1;        // {row, half}
    localparam int IDX_W   = 2 * ROW_AW;
    localparam int DC_SHIFT = 2;

    typedef enum logic [1:0] {
        DP_COL_FULL = 2'd0,
        DP_COL_RED  = 2'd1,
        DP_ROW_FULL = 2'd2,
        DP_ROW_RED  = 2'd3
    } dp_mode_e;

    typedef enum logic [1:0] {
        HC_FULL, HC_RED, HC_DC, HC_ZERO
    } half_class_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_COL, ST_ROW, ST_EMIT, ST_DONE
    } seq_state_e;
endpackage

// File: rtl/idct_half_cls.sv
module idct_half_cls
    import idct_seq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     row_vld,
    input  logic [ROW_AW-1:0]        row_idx,
    input  logic [HALF_W*CW-1:0]     row_data,
    output half_class_e              cls
);
    typedef struct packed {
        logic hi_nz;   // any nonzero in rows 4..7
        logic ac_nz;   // any nonzero in rows 1..7
        logic dc_nz;   // any nonzero in row 0
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        logic nz;
        f_d = f_q;
        nz  = |row_data;
        if (clr) begin
            f_d = '0;
        end else if (row_vld) begin
            if (row_idx[ROW_AW-1])   f_d.hi_nz = f_q.hi_nz | nz;
            if (row_idx != '0)       f_d.ac_nz = f_q.ac_nz | nz;
            else                     f_d.dc_nz = f_q.dc_nz | nz;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        if (f_q.hi_nz)      cls = HC_FULL;
        else if (f_q.ac_nz) cls = HC_RED;
        else if (f_q.dc_nz) cls = HC_DC;
        else                cls = HC_ZERO;
    end

    // a cleared classifier must report an all-zero half
    assert_clear_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cls == HC_ZERO));
endmodule

// File: rtl/idct_ws_bank.sv
module idct_ws_bank
    import idct_seq_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ROW_AW-1:0]         wr_row,
    input  logic [HALF_W-1:0][WW-1:0] wr_data,
    input  logic [1:0]                rd_pos,
    output logic [BLK-1:0][WW-1:0]    rd_data
);
    logic [BLK-1:0][HALF_W-1:0][WW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_row] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // column read: entry rd_pos of every workspace row, row order = lane order
    for (genvar j = 0; j < BLK; j++) begin : g_rd
        assign rd_data[j] = mem_q[j][rd_pos];
    end
endmodule

// File: rtl/idct_zskip_seq.sv
module idct_zskip_seq
    import idct_seq_pkg::*;
#(
    parameter int CW = 16,
    parameter int QW = 16,
    parameter int WW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic                 coef_rd_en,
    output logic [ADDR_W-1:0]    coef_addr,
    input  logic [HALF_W*CW-1:0] coef_rdata,
    output logic                 q_rd_en,
    output logic [ADDR_W-1:0]    q_addr,
    input  logic [HALF_W*QW-1:0] q_rdata,
    output logic                 dp_req,
    output logic [1:0]           dp_mode,
    output logic [BLK*WW-1:0]    dp_in,
    input  logic [BLK*WW-1:0]    dp_out,
    output logic                 out_valid,
    output logic [IDX_W-1:0]     out_idx,
    output logic [WW-1:0]        out_data
);
    localparam int PW = CW + QW;

    typedef struct packed {
        seq_state_e                      st;
        logic [3:0]                      cnt;
        logic                            half;
        logic                            pend;
        logic [ROW_AW-1:0]               prow;
        logic [BLK-1:0][HALF_W-1:0][WW-1:0] dq;
        logic                            rz;
        logic [ROW_AW-1:0]               krow;
        logic [BLK-1:0][WW-1:0]          rowbuf;
        logic                            ovld;
        logic [IDX_W-1:0]                oidx;
        logic [WW-1:0]                   odata;
        logic                            done;
    } seq_t;

    seq_t s_d, s_q;

    half_class_e                cls;
    logic                       cls_clr;
    logic [HALF_W-1:0][WW-1:0]  dq_row;
    logic signed [PW-1:0]       prod [HALF_W];
    logic                       rd_en_c, req_c;
    dp_mode_e                   mode_c;
    logic [BLK-1:0][WW-1:0]     din_c, dout_v, wsl_rd, wsr_rd;
    logic                       wsl_we, wsr_we;
    logic [HALF_W-1:0][WW-1:0]  wsl_wd, wsr_wd;
    logic [ROW_AW-1:0]          ws_row;
    logic [WW-1:0]              dc_val;

    assign dout_v = dp_out;

    always_comb begin
        for (int i = 0; i < HALF_W; i++) begin
            prod[i]   = $signed(coef_rdata[i*CW +: CW]) * $signed(q_rdata[i*QW +: QW]);
            dq_row[i] = prod[i][WW-1:0];
        end
    end

    idct_half_cls #(.CW(CW)) u_cls (
        .clk(clk), .rst_n(rst_n), .clr(cls_clr), .row_vld(s_q.pend),
        .row_idx(s_q.prow), .row_data(coef_rdata), .cls(cls));

    idct_ws_bank #(.WW(WW)) u_ws_lo (
        .clk(clk), .rst_n(rst_n), .wr_en(wsl_we), .wr_row(ws_row),
        .wr_data(wsl_wd), .rd_pos(s_q.krow[1:0]), .rd_data(wsl_rd));

    idct_ws_bank #(.WW(WW)) u_ws_hi (
        .clk(clk), .rst_n(rst_n), .wr_en(wsr_we), .wr_row(ws_row),
        .wr_data(wsr_wd), .rd_pos(s_q.krow[1:0]), .rd_data(wsr_rd));

    always_comb begin
        s_d      = s_q;
        s_d.pend = 1'b0;
        s_d.ovld = 1'b0;
        s_d.done = 1'b0;
        rd_en_c  = 1'b0;
        req_c    = 1'b0;
        mode_c   = DP_COL_FULL;
        din_c    = '0;
        cls_clr  = 1'b0;
        wsl_we   = 1'b0;
        wsr_we   = 1'b0;
        wsl_wd   = '0;
        wsr_wd   = '0;
        ws_row   = {s_q.half, s_q.cnt[1:0]};
        dc_val   = s_q.dq[0][s_q.cnt[1:0]] << DC_SHIFT;

        if (s_q.pend) s_d.dq[s_q.prow] = dq_row;

        unique case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.st   = ST_LOAD;
                s_d.half = 1'b0;
                s_d.cnt  = '0;
                s_d.rz   = 1'b0;
                cls_clr  = 1'b1;
            end
            ST_LOAD: begin
                if (s_q.cnt < 4'(BLK)) begin
                    rd_en_c  = 1'b1;
                    s_d.pend = 1'b1;
                    s_d.prow = s_q.cnt[ROW_AW-1:0];
                end
                s_d.cnt = s_q.cnt + 4'd1;
                if (s_q.cnt == 4'(BLK)) begin
                    s_d.st  = ST_COL;
                    s_d.cnt = '0;
                end
            end
            ST_COL: begin
                if (cls == HC_FULL || cls == HC_RED) begin
                    req_c  = 1'b1;
                    mode_c = (cls == HC_RED) ? DP_COL_RED : DP_COL_FULL;
                    for (int j = 0; j < BLK; j++) din_c[j] = s_q.dq[j][s_q.cnt[1:0]];
                    wsl_we = 1'b1;
                    wsr_we = 1'b1;
                    for (int k = 0; k < HALF_W; k++) begin
                        wsl_wd[k] = dout_v[k];
                        wsr_wd[k] = dout_v[k+HALF_W];
                    end
                end else if (cls == HC_ZERO && s_q.half) begin
                    s_d.rz = 1'b1;
                end else begin
                    wsl_we = 1'b1;
                    wsr_we = 1'b1;
                    wsl_wd = {HALF_W{dc_val}};
                    wsr_wd = {HALF_W{dc_val}};
                end
                s_d.cnt = s_q.cnt + 4'd1;
                if (s_q.cnt == 4'(HALF_W - 1)) begin
                    s_d.cnt = '0;
                    if (!s_q.half) begin
                        s_d.half = 1'b1;
                        s_d.st   = ST_LOAD;
                        cls_clr  = 1'b1;
                    end else begin
                        s_d.st   = ST_ROW;
                        s_d.krow = '0;
                    end
                end
            end
            ST_ROW: begin
                req_c  = 1'b1;
                mode_c = s_q.rz ? DP_ROW_RED : DP_ROW_FULL;
                for (int j = 0; j < BLK; j++) begin
                    if (s_q.rz && j >= HALF_W) din_c[j] = '0;
                    else din_c[j] = s_q.krow[ROW_AW-1] ? wsr_rd[j] : wsl_rd[j];
                end
                s_d.rowbuf = dout_v;
                s_d.st     = ST_EMIT;
                s_d.cnt    = '0;
            end
            ST_EMIT: begin
                s_d.ovld  = 1'b1;
                s_d.oidx  = {s_q.krow, s_q.cnt[ROW_AW-1:0]};
                s_d.odata = s_q.rowbuf[s_q.cnt[ROW_AW-1:0]];
                s_d.cnt   = s_q.cnt + 4'd1;
                if (s_q.cnt == 4'(BLK - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.krow == ROW_AW'(BLK - 1)) s_d.st = ST_DONE;
                    else begin
                        s_d.krow = s_q.krow + 1'b1;
                        s_d.st   = ST_ROW;
                    end
                end
            end
            ST_DONE: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;
    assign coef_rd_en = rd_en_c;
    assign q_rd_en    = rd_en_c;
    assign coef_addr  = {s_q.cnt[ROW_AW-1:0], s_q.half};
    assign q_addr     = {s_q.cnt[ROW_AW-1:0], s_q.half};
    assign dp_req     = req_c;
    assign dp_mode    = mode_c;
    assign dp_in      = din_c;
    assign out_valid  = s_q.ovld;
    assign out_idx    = s_q.oidx;
    assign out_data   = s_q.odata;

    // no datapath issue while a half is still being fetched
    assert_no_issue_in_fetch_R13: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_en |-> !dp_req);
    // reduced row pass never consumes workspace rows 4..7
    assert_reduced_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && dp_mode == 2'd3) |-> (dp_in[BLK*WW-1:HALF_W*WW] == '0));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_idx) == IDX_W'(BLK*BLK - 1)));
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
    assert_sample_in_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

// File: tb/tb_idct_zskip_seq.sv
`timescale 1ns/1ps
module tb_idct_zskip_seq;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, coef_rd_en, q_rd_en, dp_req, out_valid;
    logic [3:0] coef_addr, q_addr;
    logic [4*W-1:0] coef_rdata = '0, q_rdata = '0;
    logic [1:0] dp_mode;
    logic [8*W-1:0] dp_in, dp_out;
    logic [5:0] out_idx;
    logic [W-1:0] out_data;

    always #2 clk = ~clk;   // 250 MHz

    idct_zskip_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .coef_rd_en(coef_rd_en), .coef_addr(coef_addr), .coef_rdata(coef_rdata),
        .q_rd_en(q_rd_en), .q_addr(q_addr), .q_rdata(q_rdata),
        .dp_req(dp_req), .dp_mode(dp_mode), .dp_in(dp_in), .dp_out(dp_out),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data));

    // datapath stand-in: position-weighted sum plus mode offset, all lanes used
    function automatic logic [W-1:0] dp_lane(input logic [8*W-1:0] din,
                                            input logic [1:0] mode, input int k);
        logic [W-1:0] acc;
        acc = W'(mode) * W'(7 * (k + 1));
        for (int j = 0; j < 8; j++)
            acc = acc + din[j*W +: W] * W'(((3*j + 5*k) % 7) + 1);
        return acc;
    endfunction

    always_comb begin
        for (int k = 0; k < 8; k++) dp_out[k*W +: W] = dp_lane(dp_in, dp_mode, k);
    end

    logic [4*W-1:0] cmem [16];
    logic [4*W-1:0] qmem [16];
    always @(posedge clk) begin
        if (coef_rd_en) coef_rdata <= cmem[coef_addr];
        if (q_rd_en)    q_rdata    <= qmem[q_addr];
    end

    logic [W-1:0] cf [8][8];
    logic [W-1:0] qt [8][8];
    logic [W-1:0] exp_q [$];
    logic [5:0]   exp_idx = '0;
    int nchk = 0, nfail = 0, cyc = 0, start_cyc = 0, done_cnt = 0;
    logic last63 = 1'b0;
    string tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic fail(input string req, input string what, input longint act, input longint expv);
        nfail++;
        $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    nchk++;
                    fail("R12", "sample with empty queue", out_idx, -1);
                end else begin
                    logic [W-1:0] e;
                    int due;
                    e = exp_q.pop_front();
                    due = 28 + 9 * int'(exp_idx[5:3]) + int'(exp_idx[2:0]);
                    nchk++;
                    if (out_data !== e) fail(tag, "R10 sample data", out_data, e);
                    else if (out_idx !== exp_idx) fail(tag, "R10 sample index", out_idx, exp_idx);
                    else if (cyc - start_cyc - 1 != due) fail(tag, "R10 sample cycle", cyc - start_cyc - 1, due);
                    exp_idx = exp_idx + 6'd1;
                end
            end
            if (done) begin
                nchk++;
                done_cnt++;
                if (!last63) fail("R11", "done without preceding sample 63", 0, 1);
                else if (cyc - start_cyc - 1 != 99) fail("R11", "done cycle", cyc - start_cyc - 1, 99);
            end
            last63 = out_valid && (out_idx == 6'd63);
            if (dp_req) begin
                nchk++;
                if (coef_rd_en) fail("R13", "request during fetch", 1, 0);
                if (dp_mode == 2'd3 && dp_in[8*W-1:4*W] != '0)
                    fail("R7", "reduced row upper lanes", dp_in[8*W-1:4*W] != '0, 0);
            end
            if (coef_rd_en) begin
                nchk++;
                if (!q_rd_en || q_addr !== coef_addr) fail("R2", "address pairing", q_addr, coef_addr);
            end
        end
    end

    task automatic gen(input int kind);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int t;
                t = $urandom_range(0, 200);
                cf[r][c] = W'(t - 100);
                qt[r][c] = W'(1 + (r * 8 + c) % 11);
                if (kind == 6) begin
                    cf[r][c] = W'(t * 150 - 15000);
                    qt[r][c] = W'(100 + r * 8 + c);
                end
            end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                case (kind)
                    1: if (c < 4 && r >= 4) cf[r][c] = '0;
                    2: if ((c < 4 && r >= 1) || (c >= 4 && r >= 4)) cf[r][c] = '0;
                    3: if (c < 4 || r >= 1) cf[r][c] = '0;
                    4: if (c >= 4) cf[r][c] = '0;
                    5: cf[r][c] = '0;
                    7: if (c >= 4 || r >= 1) cf[r][c] = '0;
                    default: ;
                endcase
            end
        case (kind)
            0, 6: begin cf[7][1] = W'(5); cf[6][6] = W'(-3); end
            1: begin cf[1][2] = W'(9); cf[5][5] = W'(2); end
            2: begin cf[0][1] = W'(-11); cf[2][5] = W'(4); end
            3: begin cf[0][4] = W'(6); cf[0][7] = W'(-8); end
            4: cf[6][0] = W'(7);
            7: begin cf[0][0] = W'(20000); cf[0][3] = W'(-77); end
            default: ;
        endcase
    endtask

    task automatic load_and_predict();
        logic [W-1:0] dq [8][8];
        logic [W-1:0] wl [8][4];
        logic [W-1:0] wr [8][4];
        logic [8*W-1:0] din;
        logic rz;
        rz = 1'b0;
        for (int r = 0; r < 8; r++)
            for (int h = 0; h < 2; h++)
                for (int i = 0; i < 4; i++) begin
                    cmem[r*2+h][i*W +: W] = cf[r][4*h+i];
                    qmem[r*2+h][i*W +: W] = qt[r][4*h+i];
                end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                dq[r][c] = cf[r][c] * qt[r][c];          // R3 wrap
                if (c < 4) begin wl[r][c] = '0; wr[r][c] = '0; end
            end
        for (int h = 0; h < 2; h++) begin
            logic hi, ac, al;
            hi = 0; ac = 0; al = 0;
            for (int r = 0; r < 8; r++)
                for (int i = 0; i < 4; i++) begin
                    if (cf[r][4*h+i] != 0) begin
                        al = 1;
                        if (r >= 1) ac = 1;
                        if (r >= 4) hi = 1;
                    end
                end
            for (int c = 0; c < 4; c++) begin
                int col;
                col = 4 * h + c;
                if (h == 1 && !al) rz = 1'b1;                       // R7
                else if (!ac) begin                                 // R6
                    for (int k = 0; k < 4; k++) begin
                        wl[col][k] = dq[0][col] << 2;
                        wr[col][k] = dq[0][col] << 2;
                    end
                end else begin                                      // R4 R5 R9
                    for (int j = 0; j < 8; j++) din[j*W +: W] = dq[j][col];
                    for (int k = 0; k < 4; k++) begin
                        wl[col][k] = dp_lane(din, hi ? 2'd0 : 2'd1, k);
                        wr[col][k] = dp_lane(din, hi ? 2'd0 : 2'd1, k + 4);
                    end
                end
            end
        end
        for (int k = 0; k < 8; k++) begin                           // R8 R9
            for (int j = 0; j < 8; j++)
                din[j*W +: W] = (rz && j >= 4) ? W'(0) : (k < 4 ? wl[j][k] : wr[j][k-4]);
            for (int j = 0; j < 8; j++) exp_q.push_back(dp_lane(din, rz ? 2'd3 : 2'd2, j));
        end
    endtask

    task automatic run_block(input int kind, input string t, input bool_extra_start);
        int d0, guard;
        gen(kind);
        tag = t;
        load_and_predict();
        @(negedge clk);
        start_cyc = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nchk++;
        if (!busy) fail("R12", "busy after start", busy, 1);
        if (bool_extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;                                           // R12
            @(negedge clk);
            start = 1'b0;
        end
        d0 = done_cnt;
        guard = 0;
        while (done_cnt == d0 && guard < 1000) begin @(posedge clk); guard++; end
        @(negedge clk);
        nchk++;
        if (exp_q.size() != 0) fail(t, "R10 samples missing", exp_q.size(), 0);
        exp_q.delete();
        nchk++;
        if (busy) fail("R11", "busy after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 16; a++) begin cmem[a] = '0; qmem[a] = '0; end
        repeat (3) @(negedge clk);
        nchk++;
        if (busy || done || out_valid) fail("R1", "outputs in reset", {busy, done, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        nchk++;
        if (busy || done || out_valid) fail("R1", "outputs after reset", {busy, done, out_valid}, 0);

        run_block(0, "R4 R2 full halves", 1'b0);
        run_block(1, "R5 left reduced", 1'b0);
        run_block(2, "R6 left dc right reduced", 1'b0);
        run_block(3, "R6 left zero right dc", 1'b0);
        run_block(0, "R4 refill workspace", 1'b0);
        run_block(4, "R7 right zero stale rows", 1'b0);
        run_block(5, "R7 all zero", 1'b0);
        run_block(6, "R3 wrapping products", 1'b0);
        run_block(7, "R3 dc shift wrap R7", 1'b0);
        run_block(0, "R12 start while busy", 1'b1);
        repeat (150) @(negedge clk);
        nchk++;
        if (busy || done_cnt != 10) fail("R12", "extra block started", done_cnt, 10);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule